// File: doc/BRIEF.md
# Masked-Write GPIO Bank Register File

This block holds the direction and drive state for several banks of general-purpose pins. Each bank has a direction register and a drive-value register. Both are reached over a simple register bus with a 7-bit address and a 32-bit data word. Every write to one of these registers carries its own bit-enable mask in the upper half of the word. Software can therefore flip a single pin without first reading the register back.

A separate debug-select register holds one bit per bank. When a bank's bit is set, that bank's pin drive values come from an internal debug bus instead of the drive-value register. Direction still comes from the direction register.

The pin-facing outputs are registered. A reader on the bus gets back the direction registers, the debug-select bits, or the sampled pin levels of a bank.

Top module: `gpio_bank_regs`

## Requirements
- R1: After reset every direction bit, drive bit and debug-select bit is 0. `pin_oe` and `pin_out` read all zeros.
- R2: A write to a direction address updates bit i of that bank's direction register to `wdata[i]` wherever `wdata[16+i]` is 1. All bits whose mask bit is 0 keep their value. A 1 in `pin_oe` makes the pin an output and a 0 makes it an input.
- R3: A write to a drive-value address applies the same masked update to that bank's drive register, with `wdata[31:16]` as the mask and `wdata[15:0]` as the values. A bank with debug-select clear shows its drive register on its slice of `pin_out`.
- R4: Bank b (0 to 3) has its direction register at address 5+b and its drive register at address 9+b. Bank b occupies bits 16b+15:16b of `pin_oe`, `pin_out`, `pin_in` and `dbg_val`. A write to one bank leaves the other banks unchanged.
- R5: Address 14 holds the debug-select bits: bit b is `wdata[b]`, and the write is unmasked. While bit b is set, the `pin_out` slice of bank b follows `dbg_val` of bank b with one cycle of delay, and `pin_oe` is unaffected.
- R6: A write to any address other than 5 to 12 and 14 changes no register and no output.
- R7: A read of address 5+b returns the direction register of bank b in bits 15:0 and zero in bits 31:16.
- R8: A read of address 9+b returns the sampled levels of bank b's `pin_in` in bits 15:0 and zero in bits 31:16. The sample is the value from the clock edge before the read strobe.
- R9: A read of address 14 returns the debug-select bits, zero-extended. A read of any other unmapped address returns 0. `rdata` is valid after the clock edge that samples `rd_en`.
- R10: A register write takes effect on the clock edge that samples `wr_en`. The change appears on `pin_oe` and `pin_out` one clock edge later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 7 | Register address |
| wdata | input | 32 | Write data: mask in 31:16, values in 15:0 |
| rdata | output | 32 | Registered read data |
| pin_in | input | 64 | Pin levels from the pads, four banks of 16 |
| dbg_val | input | 64 | Internal debug drive values, four banks of 16 |
| pin_oe | output | 64 | Per-pin output enable, 1 = drive |
| pin_out | output | 64 | Per-pin drive value |

## Verification
The hardest case to reach from the ports is a bank under debug override whose drive register is changed in the background. The override has to hide the change on `pin_out`, and clearing the override must then reveal the new value. The stimulus first gives the debug bus and the drive register values that differ. It then sets debug-select for one bank and checks that bank's slice against the debug bus while the other banks keep their drive values. Next it moves the debug bus and checks that the slice follows one cycle later. Finally it clears debug-select and checks that the drive register value reappears.

// File: rtl/gpio_regs_pkg.sv
package gpio_regs_pkg;
  // Bank b direction register at OE_BASE+b, drive register at VAL_BASE+b
  localparam int unsigned OE_BASE  = 5;
  localparam int unsigned VAL_BASE = 9;
  localparam int unsigned DBG_ADDR = 14;
endpackage

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
  import gpio_regs_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 4,
  parameter int unsigned ADDR_W    = 7
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  output logic [NUM_BANKS-1:0] oe_we,
  output logic [NUM_BANKS-1:0] val_we,
  output logic              dbg_we
);
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_dec
    localparam logic [ADDR_W-1:0] OE_A  = ADDR_W'(OE_BASE + b);
    localparam logic [ADDR_W-1:0] VAL_A = ADDR_W'(VAL_BASE + b);
    assign oe_we[b]  = wr_en && (addr == OE_A);
    assign val_we[b] = wr_en && (addr == VAL_A);
  end

  assign dbg_we = wr_en && (addr == ADDR_W'(DBG_ADDR));
endmodule

// File: rtl/gpio_mask_reg.sv
module gpio_mask_reg #(
  parameter int unsigned WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [WIDTH-1:0] bit_en,
  input  logic [WIDTH-1:0] bit_val,
  output logic [WIDTH-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else if (we) begin
      q <= (q & ~bit_en) | (bit_val & bit_en);
    end
  end
endmodule

// File: rtl/gpio_pin_drive.sv
module gpio_pin_drive #(
  parameter int unsigned NUM_BANKS = 4,
  parameter int unsigned BANK_W    = 16,
  localparam int unsigned PINS     = NUM_BANKS * BANK_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [PINS-1:0]      oe_q,
  input  logic [PINS-1:0]      val_q,
  input  logic [NUM_BANKS-1:0] dbg_en,
  input  logic [PINS-1:0]      dbg_val,
  output logic [PINS-1:0]      pin_oe,
  output logic [PINS-1:0]      pin_out
);
  logic [PINS-1:0] drv_nxt;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_mux
    assign drv_nxt[b*BANK_W +: BANK_W] = dbg_en[b] ? dbg_val[b*BANK_W +: BANK_W]
                                                   : val_q[b*BANK_W +: BANK_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_oe  <= '0;
      pin_out <= '0;
    end else begin
      pin_oe  <= oe_q;
      pin_out <= drv_nxt;
    end
  end
endmodule

// File: rtl/gpio_readback.sv
module gpio_readback
  import gpio_regs_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 4,
  parameter int unsigned BANK_W    = 16,
  parameter int unsigned ADDR_W    = 7,
  parameter int unsigned DATA_W    = 32,
  localparam int unsigned PINS     = NUM_BANKS * BANK_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 rd_en,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [PINS-1:0]      oe_q,
  input  logic [PINS-1:0]      pin_smp,
  input  logic [NUM_BANKS-1:0] dbg_en,
  output logic [DATA_W-1:0]    rdata
);
  logic [DATA_W-1:0] sel;

  always_comb begin
    sel = '0;
    for (int unsigned b = 0; b < NUM_BANKS; b++) begin
      if (addr == ADDR_W'(OE_BASE + b))  sel = DATA_W'(oe_q[b*BANK_W +: BANK_W]);
      if (addr == ADDR_W'(VAL_BASE + b)) sel = DATA_W'(pin_smp[b*BANK_W +: BANK_W]);
    end
    if (addr == ADDR_W'(DBG_ADDR)) sel = DATA_W'(dbg_en);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_en) begin
      rdata <= sel;
    end
  end
endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs #(
  parameter int unsigned NUM_BANKS = 4,
  parameter int unsigned BANK_W    = 16,
  parameter int unsigned ADDR_W    = 7,
  parameter int unsigned DATA_W    = 32,
  localparam int unsigned PINS     = NUM_BANKS * BANK_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic [PINS-1:0]   pin_in,
  input  logic [PINS-1:0]   dbg_val,
  output logic [PINS-1:0]   pin_oe,
  output logic [PINS-1:0]   pin_out
);
  logic [NUM_BANKS-1:0] oe_we;
  logic [NUM_BANKS-1:0] val_we;
  logic                 dbg_we;
  logic [PINS-1:0]      oe_q;
  logic [PINS-1:0]      val_q;
  logic [PINS-1:0]      pin_smp;
  logic [NUM_BANKS-1:0] dbg_en_q;
  logic [BANK_W-1:0]    wr_mask;
  logic [BANK_W-1:0]    wr_bits;

  assign wr_mask = wdata[2*BANK_W-1:BANK_W];
  assign wr_bits = wdata[BANK_W-1:0];

  gpio_addr_decode #(.NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W)) dec_i (
    .wr_en(wr_en), .addr(addr), .oe_we(oe_we), .val_we(val_we), .dbg_we(dbg_we)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    gpio_mask_reg #(.WIDTH(BANK_W)) oe_reg_i (
      .clk(clk), .rst(rst), .we(oe_we[b]), .bit_en(wr_mask), .bit_val(wr_bits),
      .q(oe_q[b*BANK_W +: BANK_W])
    );
    gpio_mask_reg #(.WIDTH(BANK_W)) val_reg_i (
      .clk(clk), .rst(rst), .we(val_we[b]), .bit_en(wr_mask), .bit_val(wr_bits),
      .q(val_q[b*BANK_W +: BANK_W])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dbg_en_q <= '0;
      pin_smp  <= '0;
    end else begin
      pin_smp <= pin_in;
      if (dbg_we) dbg_en_q <= wdata[NUM_BANKS-1:0];
    end
  end

  gpio_pin_drive #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W)) drv_i (
    .clk(clk), .rst(rst), .oe_q(oe_q), .val_q(val_q), .dbg_en(dbg_en_q),
    .dbg_val(dbg_val), .pin_oe(pin_oe), .pin_out(pin_out)
  );

  gpio_readback #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W), .ADDR_W(ADDR_W),
                  .DATA_W(DATA_W)) rb_i (
    .clk(clk), .rst(rst), .rd_en(rd_en), .addr(addr), .oe_q(oe_q),
    .pin_smp(pin_smp), .dbg_en(dbg_en_q), .rdata(rdata)
  );
endmodule

// File: rtl/gpio_bank_regs_chk.sv
module gpio_bank_regs_chk
  import gpio_regs_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 4,
  parameter int unsigned BANK_W    = 16,
  parameter int unsigned ADDR_W    = 7,
  parameter int unsigned DATA_W    = 32,
  localparam int unsigned PINS     = NUM_BANKS * BANK_W
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 wr_en,
  input logic                 rd_en,
  input logic [ADDR_W-1:0]    addr,
  input logic [DATA_W-1:0]    wdata,
  input logic [DATA_W-1:0]    rdata,
  input logic [PINS-1:0]      dbg_val,
  input logic [PINS-1:0]      pin_oe,
  input logic [PINS-1:0]      pin_out,
  input logic [PINS-1:0]      oe_q,
  input logic [PINS-1:0]      val_q,
  input logic [NUM_BANKS-1:0] dbg_en_q
);
  logic mapped;
  logic [BANK_W-1:0] msk;
  logic [BANK_W-1:0] bits;

  assign msk  = wdata[2*BANK_W-1:BANK_W];
  assign bits = wdata[BANK_W-1:0];

  always_comb begin
    mapped = (addr == ADDR_W'(DBG_ADDR));
    for (int unsigned b = 0; b < NUM_BANKS; b++) begin
      if (addr == ADDR_W'(OE_BASE + b) || addr == ADDR_W'(VAL_BASE + b)) mapped = 1'b1;
    end
  end

  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (pin_oe == '0 && pin_out == '0 && oe_q == '0 && dbg_en_q == '0));

  // R6
  unmapped_write_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !mapped) |=> ($stable(oe_q) && $stable(val_q) && $stable(dbg_en_q)));

  // R10
  pin_lag_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (pin_oe == $past(oe_q)));

  // R9
  dbg_read_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == ADDR_W'(DBG_ADDR)) |=> (rdata == DATA_W'($past(dbg_en_q))));

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank_chk
    // R2
    oe_mask_chk: assert property (@(posedge clk) disable iff (rst)
      (wr_en && addr == ADDR_W'(OE_BASE + b)) |=>
        (oe_q[b*BANK_W +: BANK_W] == (($past(msk) & $past(bits)) |
                                      (~$past(msk) & $past(oe_q[b*BANK_W +: BANK_W])))));
    // R3
    val_mask_chk: assert property (@(posedge clk) disable iff (rst)
      (wr_en && addr == ADDR_W'(VAL_BASE + b)) |=>
        (val_q[b*BANK_W +: BANK_W] == (($past(msk) & $past(bits)) |
                                       (~$past(msk) & $past(val_q[b*BANK_W +: BANK_W])))));
    // R5
    dbg_sel_chk: assert property (@(posedge clk) disable iff (rst)
      dbg_en_q[b] |=> (pin_out[b*BANK_W +: BANK_W] == $past(dbg_val[b*BANK_W +: BANK_W])));
    // R3
    drive_sel_chk: assert property (@(posedge clk) disable iff (rst)
      !dbg_en_q[b] |=> (pin_out[b*BANK_W +: BANK_W] == $past(val_q[b*BANK_W +: BANK_W])));
    // R7
    oe_read_chk: assert property (@(posedge clk) disable iff (rst)
      (rd_en && addr == ADDR_W'(OE_BASE + b)) |=>
        (rdata == DATA_W'($past(oe_q[b*BANK_W +: BANK_W]))));
  end
endmodule

bind gpio_bank_regs gpio_bank_regs_chk #(
  .NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) chk_i (
  .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
  .rdata(rdata), .dbg_val(dbg_val), .pin_oe(pin_oe), .pin_out(pin_out),
  .oe_q(oe_q), .val_q(val_q), .dbg_en_q(dbg_en_q)
);

// File: tb/gpio_bank_regs_tb.sv
module gpio_bank_regs_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [6:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [63:0] pin_in = '0;
  logic [63:0] dbg_val = '0;
  logic [63:0] pin_oe;
  logic [63:0] pin_out;

  int total = 0;
  int bad = 0;
  logic [15:0] m_oe [4];
  logic [15:0] m_val [4];
  logic [3:0]  m_dbg;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_bank_regs dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .pin_in(pin_in), .dbg_val(dbg_val), .pin_oe(pin_oe), .pin_out(pin_out)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] exp_oe();
    return {m_oe[3], m_oe[2], m_oe[1], m_oe[0]};
  endfunction

  function automatic logic [63:0] exp_out();
    logic [63:0] r;
    for (int b = 0; b < 4; b++)
      r[b*16 +: 16] = m_dbg[b] ? dbg_val[b*16 +: 16] : m_val[b];
    return r;
  endfunction

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  // masked write with model update; waits until pins reflect it
  task automatic mwr(input int bank, input bit is_oe, input logic [15:0] m, input logic [15:0] v);
    if (is_oe) begin
      m_oe[bank] = (m_oe[bank] & ~m) | (v & m);
      wr(7'(5 + bank), {m, v});
    end else begin
      m_val[bank] = (m_val[bank] & ~m) | (v & m);
      wr(7'(9 + bank), {m, v});
    end
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 pin_oe", pin_oe, 64'h0);
    chk("R1 pin_out", pin_out, 64'h0);
    rd(7'd5, d);  chk("R1 oe bank0 read", 64'(d), 64'h0);
    rd(7'd14, d); chk("R1 dbg read", 64'(d), 64'h0);
  endtask

  task automatic t_oe_mask();
    logic [31:0] d;
    mwr(0, 1, 16'hFFFF, 16'hA5A5);
    chk("R2 full mask", pin_oe, exp_oe());
    mwr(0, 1, 16'h00F0, 16'h0000);
    chk("R2 partial mask", pin_oe, exp_oe());
    chk("R2 partial mask value", 64'(pin_oe[15:0]), 64'hA505);
    mwr(0, 1, 16'h0000, 16'hFFFF);
    chk("R2 zero mask", 64'(pin_oe[15:0]), 64'hA505);
  endtask

  task automatic t_val_mask();
    mwr(2, 0, 16'hFFFF, 16'h1234);
    chk("R3 full write", pin_out, exp_out());
    mwr(2, 0, 16'h8001, 16'hFFFF);
    chk("R3 single bits", 64'(pin_out[47:32]), 64'h9235);
  endtask

  task automatic t_banks();
    mwr(3, 1, 16'hFFFF, 16'h0F0F);
    mwr(1, 0, 16'hFFFF, 16'hBEEF);
    mwr(1, 1, 16'h00FF, 16'h00C3);
    chk("R4 oe all banks", pin_oe, exp_oe());
    chk("R4 out all banks", pin_out, exp_out());
    chk("R4 bank3 slice", 64'(pin_oe[63:48]), 64'h0F0F);
  endtask

  task automatic t_debug();
    logic [63:0] oe_before;
    oe_before = pin_oe;
    dbg_val = 64'h1111_2222_3333_4444;
    m_dbg = 4'b0010;
    wr(7'd14, 32'hFFFF_0002);
    @(negedge clk);
    chk("R5 debug selects bank1", pin_out, exp_out());
    chk("R5 bank1 from debug bus", 64'(pin_out[31:16]), 64'h3333);
    chk("R5 direction unaffected", pin_oe, oe_before);
    // drive register changes while hidden behind the override
    m_val[1] = 16'h0F00;
    wr(7'd10, 32'hFFFF_0F00);
    @(negedge clk);
    chk("R5 hidden drive change", 64'(pin_out[31:16]), 64'h3333);
    dbg_val[31:16] = 16'h5A5A;
    @(negedge clk);
    chk("R5 debug follows after one edge", 64'(pin_out[31:16]), 64'h5A5A);
    m_dbg = 4'b0000;
    wr(7'd14, 32'h0);
    @(negedge clk);
    chk("R5 override released", pin_out, exp_out());
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    logic [63:0] oe_b, out_b;
    oe_b = pin_oe; out_b = pin_out;
    foreach (m_oe[i]) ;
    for (int i = 0; i < 7; i++) begin
      logic [6:0] a;
      case (i)
        0: a = 7'd0; 1: a = 7'd4; 2: a = 7'd13; 3: a = 7'd15;
        4: a = 7'd20; 5: a = 7'd31; default: a = 7'd127;
      endcase
      wr(a, 32'hFFFF_FFFF);
    end
    @(negedge clk);
    chk("R6 pin_oe unchanged", pin_oe, oe_b);
    chk("R6 pin_out unchanged", pin_out, out_b);
    rd(7'd14, d); chk("R6 dbg unchanged", 64'(d), 64'h0);
    rd(7'd8, d);  chk("R6 oe bank3 unchanged", 64'(d), 64'(m_oe[3]));
  endtask

  task automatic t_read();
    logic [31:0] d;
    pin_in = 64'hCAFE_F00D_8421_7E57;
    @(negedge clk);
    for (int b = 0; b < 4; b++) begin
      rd(7'(9 + b), d);
      chk($sformatf("R8 pin read bank%0d", b), 64'(d), 64'(pin_in[b*16 +: 16]));
      rd(7'(5 + b), d);
      chk($sformatf("R7 oe read bank%0d", b), 64'(d), 64'(m_oe[b]));
    end
    m_dbg = 4'b1010;
    wr(7'd14, 32'h0000_000A);
    rd(7'd14, d); chk("R9 dbg read", 64'(d), 64'hA);
    rd(7'd20, d); chk("R9 unmapped read", 64'(d), 64'h0);
    m_dbg = 4'b0000;
    wr(7'd14, 32'h0);
    @(negedge clk);
  endtask

  task automatic t_timing();
    logic [63:0] old_oe;
    old_oe = pin_oe;
    m_oe[0] = 16'h0001;
    wr(7'd5, 32'hFFFF_0001);
    chk("R10 pins not yet changed", pin_oe, old_oe);
    @(negedge clk);
    chk("R10 pins changed one edge later", pin_oe, exp_oe());
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int b = 0; b < 4; b++) begin m_oe[b] = '0; m_val[b] = '0; end
    m_dbg = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_oe_mask();
    t_val_mask();
    t_banks();
    t_debug();
    t_unmapped();
    t_read();
    t_timing();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule